// File: doc/BRIEF.md
# Context-Tagged Translation Lookaside Buffer

This block is a small, fully associative translation cache. Each slot keeps a virtual page number (address bits 63 down to 13), a 13-bit address-space tag and a 64-bit data word. The data word carries the physical page, the page size and the attribute bits. A lookup presents a virtual address and a context. One cycle later the block answers with a hit and the translated physical address, or with a miss that tells a software refill handler to supply the mapping. Page tables are never walked in hardware.

Software fills the table with insert commands. An insert takes a free slot if there is one. Otherwise it displaces the least recently used slot that is not pinned. Lookups that hit count as uses. Software removes mappings in two ways: one page at a time, or by clearing every non-shared mapping that belongs to one context in a single cycle. Slots flagged as shared (global) match under any context and survive a context clear.

All commands use one port with a 2-bit opcode, and each command gets a registered response in the following cycle.

Top module: `ctx_tlb`

## Requirements
- R1: A lookup (op 0) that matches a valid slot on page number and context answers in the next cycle with rsp_valid=1, rsp_hit=1, rsp_data equal to the stored word and rsp_idx equal to the slot. For an 8K page (size field 0) rsp_pa is data bits 40:13 followed by address bits 12:0.
- R2: A slot whose data bit 0 (global) is clear matches only when the lookup context equals its stored context. A slot with bit 0 set matches under any context.
- R3: The size field, data bits 62:61, selects 8K, 64K, 512K or 4M (codes 0 to 3). For a larger size, the page-number compare ignores the low 3*size bits of the page number. Those address bits pass straight into rsp_pa, and an address just past the page end misses.
- R4: A lookup that finds no match returns rsp_miss=1 and rsp_hit=0. Commands other than lookup return neither hit nor miss.
- R5: An insert (op 1) writes address, context and data into the lowest-numbered invalid slot when any exists, and reports that slot on rsp_idx. A slot is valid when data bit 63 is set.
- R6: With every slot valid, an insert replaces the least recently used slot. Both lookup hits and inserts count as uses.
- R7: A valid slot with data bit 6 (lock) set is never chosen for replacement.
- R8: An insert when every slot is valid and locked is refused. It returns rsp_err=1 and leaves every mapping in place.
- R9: A demap-page command (op 2) invalidates every slot that the same address and context would hit on.
- R10: A demap-context command (op 3) invalidates, in one cycle, every valid non-global slot whose context equals the command's context. Global slots are left intact.
- R11: After reset all slots are invalid, rsp_valid is low, and a lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 0 lookup, 1 insert, 2 demap page, 3 demap context |
| cmd_va | input | 64 | Virtual address |
| cmd_ctx | input | CTX_W | Context of the command |
| cmd_data | input | 64 | Data word for insert |
| rsp_valid | output | 1 | Response for the previous cycle's command |
| rsp_hit | output | 1 | Lookup hit |
| rsp_miss | output | 1 | Lookup miss |
| rsp_err | output | 1 | Insert refused, all slots pinned |
| rsp_idx | output | IDX_W | Slot hit or written |
| rsp_pa | output | 41 | Translated physical address |
| rsp_data | output | 64 | Data word of the hit slot |

## Verification
The bound checker watches these properties on every cycle:
- each command gets exactly one response, one cycle later;
- hit and miss are never raised together, and are never raised for commands other than a lookup;
- the error flag only ever follows an insert;
- an insert never removes a valid locked slot.

The following are shown only by the bench's scenarios, each checked against values computed from the address and data fields:
- which slot a replacement picks;
- the physical address formed for each page size;
- context and global qualification;
- the effect of the two demap commands.

// File: rtl/ctx_tlb_pkg.sv
package ctx_tlb_pkg;
  localparam int VA_W     = 64;
  localparam int DATA_W   = 64;
  localparam int PA_W     = 41;
  localparam int PG_SHIFT = 13;
  localparam int VPN_W    = VA_W - PG_SHIFT;

  // data word field positions
  localparam int D_VALID  = 63;
  localparam int D_SZ_HI  = 62;
  localparam int D_SZ_LO  = 61;
  localparam int D_PPN_HI = 40;
  localparam int D_LOCK   = 6;
  localparam int D_GLOBAL = 0;

  typedef enum logic [1:0] {
    OP_LOOKUP     = 2'd0,
    OP_INSERT     = 2'd1,
    OP_DEMAP_PAGE = 2'd2,
    OP_DEMAP_CTX  = 2'd3
  } tlb_op_e;

  // page-number bits that lie inside the page for a given size code
  function automatic logic [VPN_W-1:0] vpn_ign_mask(input logic [1:0] sz);
    return (VPN_W'(1) << (3 * sz)) - VPN_W'(1);
  endfunction

  // physical-address bits taken from the virtual address for a size code
  function automatic logic [PA_W-1:0] pa_off_mask(input logic [1:0] sz);
    return (PA_W'(1) << (PG_SHIFT + 3 * sz)) - PA_W'(1);
  endfunction
endpackage

// File: rtl/tlb_first_set.sv
module tlb_first_set #(
  parameter int N = 16,
  parameter int W = 4
) (
  input  logic [N-1:0] vec,
  output logic         any,
  output logic [W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = W'(i);
    end
    any = |vec;
  end
endmodule

// File: rtl/tlb_match.sv
module tlb_match
  import ctx_tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int CTX_W   = 13
) (
  input  logic [VPN_W-1:0] ent_vpn [ENTRIES],
  input  logic [1:0]       ent_sz  [ENTRIES],
  input  logic [CTX_W-1:0] ent_ctx [ENTRIES],
  input  logic [ENTRIES-1:0] ent_vld,
  input  logic [ENTRIES-1:0] ent_glb,
  input  logic [VPN_W-1:0] q_vpn,
  input  logic [CTX_W-1:0] q_ctx,
  output logic [ENTRIES-1:0] hit_vec,
  output logic [ENTRIES-1:0] ctx_eq
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    logic [VPN_W-1:0] diff;
    logic             vpn_eq;
    assign diff      = (ent_vpn[g] ^ q_vpn) & ~vpn_ign_mask(ent_sz[g]);
    assign vpn_eq    = (diff == '0);
    assign ctx_eq[g] = (ent_ctx[g] == q_ctx);
    assign hit_vec[g] = ent_vld[g] & vpn_eq & (ctx_eq[g] | ent_glb[g]);
  end
endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               touch,
  input  logic [IDX_W-1:0]   touch_idx,
  input  logic [ENTRIES-1:0] vld,
  input  logic [ENTRIES-1:0] lck,
  output logic [IDX_W-1:0]   victim_idx,
  output logic               victim_ok
);
  // age 0 = most recent; ages always form a permutation of 0..ENTRIES-1
  logic [IDX_W-1:0] age [ENTRIES];
  logic             free_any;
  logic [IDX_W-1:0] free_idx;
  logic             old_ok;
  logic [IDX_W-1:0] old_idx;
  logic [IDX_W-1:0] old_age;
  logic [ENTRIES-1:0] free_vec;

  assign free_vec = ~vld;

  tlb_first_set #(.N(ENTRIES), .W(IDX_W)) u_free (
    .vec(free_vec), .any(free_any), .idx(free_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) age[i] <= IDX_W'(i);
    end else if (touch) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (IDX_W'(i) == touch_idx)        age[i] <= '0;
        else if (age[i] < age[touch_idx]) age[i] <= age[i] + 1'b1;
      end
    end
  end

  always_comb begin
    old_ok  = 1'b0;
    old_idx = '0;
    old_age = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!lck[i] && (!old_ok || age[i] > old_age)) begin
        old_ok  = 1'b1;
        old_idx = IDX_W'(i);
        old_age = age[i];
      end
    end
    victim_ok  = free_any | old_ok;
    victim_idx = free_any ? free_idx : old_idx;
  end
endmodule

// File: rtl/ctx_tlb.sv
module ctx_tlb
  import ctx_tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int CTX_W   = 13,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [VA_W-1:0]   cmd_va,
  input  logic [CTX_W-1:0]  cmd_ctx,
  input  logic [DATA_W-1:0] cmd_data,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_miss,
  output logic              rsp_err,
  output logic [IDX_W-1:0]  rsp_idx,
  output logic [PA_W-1:0]   rsp_pa,
  output logic [DATA_W-1:0] rsp_data
);
  logic [VPN_W-1:0]  ent_vpn  [ENTRIES];
  logic [CTX_W-1:0]  ent_ctx  [ENTRIES];
  logic [DATA_W-1:0] ent_data [ENTRIES];
  logic [1:0]        ent_sz   [ENTRIES];
  logic [ENTRIES-1:0] vld_vec, lck_vec, glb_vec;
  logic [ENTRIES-1:0] hit_vec, ctx_eq;

  logic              hit_any;
  logic [IDX_W-1:0]  hit_idx;
  logic [DATA_W-1:0] hit_data;
  logic [PA_W-1:0]   hit_pa;
  logic [PA_W-1:0]   omask;
  logic [PA_W-1:0]   pbase;
  logic              victim_ok;
  logic [IDX_W-1:0]  victim_idx;
  logic              touch;
  logic [IDX_W-1:0]  touch_idx;
  tlb_op_e           op;

  assign op = tlb_op_e'(cmd_op);

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      vld_vec[i] = ent_data[i][D_VALID];
      lck_vec[i] = ent_data[i][D_VALID] & ent_data[i][D_LOCK];
      glb_vec[i] = ent_data[i][D_GLOBAL];
      ent_sz[i]  = ent_data[i][D_SZ_HI:D_SZ_LO];
    end
  end

  tlb_match #(.ENTRIES(ENTRIES), .CTX_W(CTX_W)) u_match (
    .ent_vpn(ent_vpn), .ent_sz(ent_sz), .ent_ctx(ent_ctx),
    .ent_vld(vld_vec), .ent_glb(glb_vec),
    .q_vpn(cmd_va[VA_W-1:PG_SHIFT]), .q_ctx(cmd_ctx),
    .hit_vec(hit_vec), .ctx_eq(ctx_eq)
  );

  tlb_first_set #(.N(ENTRIES), .W(IDX_W)) u_hit (
    .vec(hit_vec), .any(hit_any), .idx(hit_idx)
  );

  tlb_lru #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_lru (
    .clk(clk), .rst(rst), .touch(touch), .touch_idx(touch_idx),
    .vld(vld_vec), .lck(lck_vec),
    .victim_idx(victim_idx), .victim_ok(victim_ok)
  );

  always_comb begin
    touch = cmd_valid & (((op == OP_LOOKUP) & hit_any) |
                         ((op == OP_INSERT) & victim_ok));
    touch_idx = (op == OP_LOOKUP) ? hit_idx : victim_idx;
  end

  always_comb begin
    hit_data = ent_data[hit_idx];
    omask    = pa_off_mask(hit_data[D_SZ_HI:D_SZ_LO]);
    pbase    = {hit_data[D_PPN_HI:PG_SHIFT], {PG_SHIFT{1'b0}}};
    hit_pa   = (pbase & ~omask) | (cmd_va[PA_W-1:0] & omask);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_idx   <= '0;
      rsp_pa    <= '0;
      rsp_data  <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        ent_vpn[i]  <= '0;
        ent_ctx[i]  <= '0;
        ent_data[i] <= '0;
      end
    end else begin
      rsp_valid <= cmd_valid;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_err   <= 1'b0;
      if (cmd_valid) begin
        unique case (op)
          OP_LOOKUP: begin
            rsp_hit  <= hit_any;
            rsp_miss <= ~hit_any;
            rsp_idx  <= hit_idx;
            rsp_pa   <= hit_any ? hit_pa : '0;
            rsp_data <= hit_any ? hit_data : '0;
          end
          OP_INSERT: begin
            rsp_idx <= victim_idx;
            if (victim_ok) begin
              ent_vpn[victim_idx]  <= cmd_va[VA_W-1:PG_SHIFT];
              ent_ctx[victim_idx]  <= cmd_ctx;
              ent_data[victim_idx] <= cmd_data;
            end else begin
              rsp_err <= 1'b1;
            end
          end
          OP_DEMAP_PAGE: begin
            for (int i = 0; i < ENTRIES; i++)
              if (hit_vec[i]) ent_data[i][D_VALID] <= 1'b0;
          end
          OP_DEMAP_CTX: begin
            for (int i = 0; i < ENTRIES; i++)
              if (vld_vec[i] && !glb_vec[i] && ctx_eq[i])
                ent_data[i][D_VALID] <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/ctx_tlb_chk.sv
module ctx_tlb_chk
  import ctx_tlb_pkg::*;
#(
  parameter int ENTRIES = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               cmd_valid,
  input logic [1:0]         cmd_op,
  input logic               rsp_valid,
  input logic               rsp_hit,
  input logic               rsp_miss,
  input logic               rsp_err,
  input logic [ENTRIES-1:0] ent_vld,
  input logic [ENTRIES-1:0] ent_lck
);
  logic [ENTRIES-1:0] pinned;
  assign pinned = ent_vld & ent_lck;

  AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> rsp_valid); // R1

  AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> !rsp_valid); // R1

  AST_HIT_MISS_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(rsp_hit && rsp_miss)); // R4

  AST_NO_HIT_OFF_LOOKUP: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op != OP_LOOKUP) |=> (!rsp_hit && !rsp_miss)); // R4

  AST_ERR_ONLY_INSERT: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op != OP_INSERT) |=> !rsp_err); // R8

  AST_LOCK_KEPT: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == OP_INSERT) |=> (($past(pinned) & ~pinned) == '0)); // R7
endmodule

bind ctx_tlb ctx_tlb_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
  .rsp_err(rsp_err), .ent_vld(vld_vec), .ent_lck(lck_vec)
);

// File: tb/test_ctx_tlb.sv
module test_ctx_tlb;
  localparam int N = 4;
  localparam int IW = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = '0;
  logic [63:0] cmd_va = '0;
  logic [12:0] cmd_ctx = '0;
  logic [63:0] cmd_data = '0;
  logic        rsp_valid, rsp_hit, rsp_miss, rsp_err;
  logic [IW-1:0] rsp_idx;
  logic [40:0] rsp_pa;
  logic [63:0] rsp_data;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ctx_tlb #(.ENTRIES(N), .CTX_W(13)) i_ctx_tlb (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_va(cmd_va), .cmd_ctx(cmd_ctx), .cmd_data(cmd_data),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
    .rsp_err(rsp_err), .rsp_idx(rsp_idx), .rsp_pa(rsp_pa), .rsp_data(rsp_data)
  );

  function automatic logic [63:0] mk(input logic [27:0] ppn, input logic [1:0] sz,
                                     input logic lck, input logic glb);
    return {1'b1, sz, 20'b0, ppn, 6'b0, lck, 5'b00001, glb};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input logic [1:0] op, input logic [63:0] va,
                     input logic [12:0] ctx, input logic [63:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_va = va; cmd_ctx = ctx; cmd_data = d;
    @(posedge clk);
    #1;
    cmd_valid = 1'b0;
  endtask

  task automatic expect_hit(input logic [63:0] va, input logic [12:0] ctx,
                            input logic [40:0] pa, input string req);
    run(2'd0, va, ctx, '0);
    chk(rsp_valid && rsp_hit && !rsp_miss, req, {62'b0, rsp_hit, rsp_miss}, 64'h2);
    chk(rsp_pa == pa, req, 64'(rsp_pa), 64'(pa));
  endtask

  task automatic expect_miss(input logic [63:0] va, input logic [12:0] ctx,
                             input string req);
    run(2'd0, va, ctx, '0);
    chk(rsp_valid && rsp_miss && !rsp_hit, req, {62'b0, rsp_hit, rsp_miss}, 64'h1);
  endtask

  task automatic do_insert(input logic [63:0] va, input logic [12:0] ctx,
                           input logic [63:0] d, input int exp_idx, input string req);
    run(2'd1, va, ctx, d);
    chk(!rsp_err, req, 64'(rsp_err), 64'h0);
    if (exp_idx >= 0) chk(rsp_idx == IW'(exp_idx), req, 64'(rsp_idx), 64'(exp_idx));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] va;
    logic [40:0] pa;
    repeat (3) @(posedge clk);
    #1;
    chk(rsp_valid == 1'b0, "R11 reset rsp_valid", 64'(rsp_valid), 64'h0);
    @(negedge clk) rst = 1'b0;
    @(posedge clk); #1;
    expect_miss(64'h0, 13'd0, "R11 empty after reset");

    // fill four slots with 8K pages, context 5
    for (int i = 0; i < N; i++)
      do_insert(64'h0000_0000_1000_0000 | (64'(i) << 13), 13'd5,
                mk(28'(100 + i), 2'd0, 1'b0, 1'b0), i, "R5 free slot order");

    // offset sweep, right and wrong context
    for (int i = 0; i < N; i++) begin
      for (int k = 0; k < 4; k++) begin
        logic [12:0] off;
        off = (k == 0) ? 13'h0 : (k == 1) ? 13'h1 : (k == 2) ? 13'h1FFF : 13'h0ABC;
        va = 64'h0000_0000_1000_0000 | (64'(i) << 13) | 64'(off);
        pa = (41'(100 + i) << 13) | 41'(off);
        expect_hit(va, 13'd5, pa, "R1 8K translate");
        chk(rsp_data == mk(28'(100 + i), 2'd0, 1'b0, 1'b0), "R1 data word",
            rsp_data, mk(28'(100 + i), 2'd0, 1'b0, 1'b0));
        chk(rsp_idx == IW'(i), "R1 slot index", 64'(rsp_idx), 64'(i));
        expect_miss(va, 13'd6, "R2 context mismatch");
      end
    end
    @(posedge clk); #1;
    chk(rsp_valid == 1'b0, "R1 idle no response", 64'(rsp_valid), 64'h0);

    // LRU: slot 0 refreshed, slot 1 is oldest
    expect_hit(64'h0000_0000_1000_0000, 13'd5, 41'(100) << 13, "R6 refresh");
    do_insert(64'h0000_0000_0020_0000, 13'd5, mk(28'd300, 2'd0, 1'b0, 1'b0), 1,
              "R6 least recently used victim");
    expect_miss(64'h0000_0000_1000_2000, 13'd5, "R6 evicted page gone");
    expect_hit(64'h0000_0000_0020_0000, 13'd5, 41'd300 << 13, "R6 new page");
    expect_hit(64'h0000_0000_1000_0000, 13'd5, 41'(100) << 13, "R6 survivor");

    // demap page
    run(2'd2, 64'h0000_0000_0020_0000, 13'd5, '0);
    expect_miss(64'h0000_0000_0020_0000, 13'd5, "R9 demap page");
    expect_hit(64'h0000_0000_1000_4000, 13'd5, 41'(102) << 13, "R9 other page kept");

    // global mapping into the freed slot
    do_insert(64'h0000_0000_0040_0000, 13'd9, mk(28'd400, 2'd0, 1'b0, 1'b1), 1,
              "R5 reuse invalid slot");
    expect_hit(64'h0000_0000_0040_0010, 13'h1234, (41'd400 << 13) | 41'h10,
               "R2 global any context");

    // demap context 5
    run(2'd3, 64'h0, 13'd5, '0);
    expect_miss(64'h0000_0000_1000_0000, 13'd5, "R10 context cleared");
    expect_miss(64'h0000_0000_1000_6000, 13'd5, "R10 context cleared");
    expect_hit(64'h0000_0000_0040_0000, 13'd9, 41'd400 << 13, "R10 global kept");
    run(2'd2, 64'h0000_0000_0040_0000, 13'd77, '0);
    expect_miss(64'h0000_0000_0040_0000, 13'd9, "R9 global demap");

    // page size sweep
    for (int s = 0; s < 4; s++) begin
      logic [63:0] vbase;
      logic [40:0] pbase, m;
      vbase = 64'h0000_0123_4000_0000;
      pbase = 41'h1_2340_0000;
      m = (41'd1 << (13 + 3 * s)) - 41'd1;
      do_insert(vbase, 13'd3, mk(28'(pbase >> 13), 2'(s), 1'b0, 1'b0), -1, "R3 insert");
      expect_hit(vbase | (64'h2A_BCDE & 64'(m)), 13'd3,
                 pbase | (41'h2A_BCDE & m), "R3 size offset");
      expect_miss(vbase + (64'd1 << (13 + 3 * s)), 13'd3, "R3 past page end");
      run(2'd2, vbase | 64'h1234, 13'd3, '0);
      expect_miss(vbase, 13'd3, "R9 demap sized page");
    end

    // lock handling
    for (int i = 0; i < N; i++)
      do_insert(64'h0000_0000_2000_0000 | (64'(i) << 13), 13'd7,
                mk(28'(500 + i), 2'd0, 1'b1, 1'b0), i, "R7 locked fill");
    run(2'd1, 64'h0000_0000_3000_0000, 13'd7, mk(28'd600, 2'd0, 1'b0, 1'b0));
    chk(rsp_err == 1'b1, "R8 refuse insert", 64'(rsp_err), 64'h1);
    expect_miss(64'h0000_0000_3000_0000, 13'd7, "R8 nothing written");
    for (int i = 0; i < N; i++)
      expect_hit(64'h0000_0000_2000_0000 | (64'(i) << 13), 13'd7,
                 41'(500 + i) << 13, "R8 locked kept");
    run(2'd2, 64'h0000_0000_2000_4000, 13'd7, '0);
    do_insert(64'h0000_0000_3000_0000, 13'd7, mk(28'd600, 2'd0, 1'b0, 1'b0), 2,
              "R7 unlocked into free");
    do_insert(64'h0000_0000_3000_2000, 13'd7, mk(28'd601, 2'd0, 1'b0, 1'b0), 2,
              "R7 only unlocked victim");
    expect_miss(64'h0000_0000_3000_0000, 13'd7, "R7 unlocked evicted");
    expect_hit(64'h0000_0000_2000_0000, 13'd7, 41'd500 << 13, "R7 lock survives");
    expect_hit(64'h0000_0000_2000_6000, 13'd7, 41'd503 << 13, "R7 lock survives");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule